// File: doc/BRIEF.md
# Indexed Block Serial Register Slave

This block is the target side of a two-wire serial bus (SMBus/I2C style) with a single fixed 7-bit device address. It lets a bus master fill or dump a small byte-wide register bank with indexed block transfers. Both pins are oversampled by a fast system clock. Each pin passes through a two-flop synchronizer before edge detection. The block drives the data line only through an open-drain pull-low enable.

A write carries four parts in order: the device address with the direction bit low, a starting register index, a byte count, and then that many data bytes. The data bytes land in consecutive registers. A read starts the same way with the address and index, then turns the bus around with a repeated START and the address with the direction bit high. The slave first answers with a count of the registers from the index to the end of the map, and then sends the register contents from the index upward. The master ends the read by not acknowledging a byte.

The register bank sits outside this block and is reached through an address, a write strobe and a read-data return. Any read-only behaviour belongs to the bank.

Top module: `smbus_idx_slave`

## Requirements
- R1: The slave acknowledges only address bytes whose upper seven bits equal the DEV_ADDR parameter (default 7'h69, so the bytes are D2h for a write and D3h for a read). Any other address gets no acknowledge, and the rest of that transfer neither drives SDA nor writes a register.
- R2: In a write, the byte after the address is the starting index and the byte after that is the count N. The following data bytes are acknowledged and written, each with a one-cycle strobe, to index, index+1, and so on.
- R3: A write count of zero is not acknowledged, and no later byte of that transfer writes a register.
- R4: After N data bytes, any further data byte in the same write is not acknowledged and is not written.
- R5: In a read, the first byte the slave sends is NUM_REGS minus the index when the index is below NUM_REGS, and 0 otherwise. Each following byte is the register at the index, then the next index, advancing after each acknowledged byte. Bytes go out most significant bit first.
- R6: Any data byte sent for an index at or beyond NUM_REGS is 00h, whatever the bank returns.
- R7: When the master does not acknowledge a byte the slave sent, the slave releases SDA and stays off the bus until the next START.
- R8: A START or STOP at any point ends the current transfer. Registers written earlier in that transfer keep their values, and the next transfer behaves normally.
- R9: After reset, SDA is released and no write strobe is active. SDA changes only while the synchronized SCL is low, or when it is released at a START or STOP.
- R10: An acknowledge is a low on SDA that the slave holds through the whole ninth SCL high phase of the byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock pin level |
| sda_i | input | 1 | Serial data pin level (wired bus value) |
| sda_oe | output | 1 | High pulls SDA low |
| reg_addr | output | 8 | Register index currently addressed |
| reg_wdata | output | 8 | Data to write, valid with reg_we |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_rdata | input | 8 | Contents of the register at reg_addr |

## Verification
A wrong pointer shows up on the bus within one byte: a read returns a shifted or repeated register value, and a write lands in the neighbouring register, which the bench sees at the next readback. A stale byte or bit counter misplaces the acknowledge slot. That shows as a missing ACK, or as SDA held low into the following byte, during the very next ninth clock. A state that survives a NACK, START or STOP leaves SDA pulled low, or lets a write strobe fire, in the transfer that follows. Once the master releases the line, that shows at once as a low bit where a high one is expected.

// File: rtl/smbus_idx_slave.sv
module smbus_idx_slave #(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int         NUM_REGS = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic [7:0] reg_addr,
  output logic [7:0] reg_wdata,
  output logic       reg_we,
  input  logic [7:0] reg_rdata
);
  localparam logic [8:0] MAP_END = 9'(NUM_REGS);

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_OFS, S_CNT, S_WDAT, S_RCNT, S_RDAT, S_SKIP} st_t;

  st_t        state, nst;
  logic [1:0] scl_sy, sda_sy;
  logic       scl_q, sda_q;
  logic [3:0] bitcnt;
  logic [7:0] sr, tx, ptr, remain;

  wire scl_s     = scl_sy[1];
  wire sda_s     = sda_sy[1];
  wire scl_rise  = scl_s & ~scl_q;
  wire scl_fall  = ~scl_s & scl_q;
  wire start_det = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  wire tx_mode   = (state == S_RCNT) || (state == S_RDAT);
  wire in_map    = {1'b0, ptr} < MAP_END;
  wire [7:0] cnt_val = in_map ? 8'(MAP_END) - ptr : 8'h00;
  wire [7:0] rd_val  = in_map ? reg_rdata : 8'h00;
  wire [7:0] ld_val  = (nst == S_RCNT) ? cnt_val : rd_val;

  assign reg_addr  = ptr;
  assign reg_wdata = sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      nst    <= S_IDLE;
      bitcnt <= '0;
      sr     <= '0;
      tx     <= '0;
      ptr    <= '0;
      remain <= '0;
      sda_oe <= 1'b0;
      reg_we <= 1'b0;
    end else begin
      reg_we <= 1'b0;
      if (start_det) begin
        state  <= S_DEV;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= S_IDLE;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (state != S_IDLE && state != S_SKIP) begin
        if (scl_rise) begin
          if (bitcnt < 4'd8) begin
            sr     <= {sr[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end else if (bitcnt == 4'd8 && tx_mode) begin
            if (sda_s) state <= S_SKIP;
            else begin
              bitcnt <= 4'd9;
              nst    <= S_RDAT;
              if (state == S_RDAT) ptr <= ptr + 8'd1;
            end
          end
        end else if (scl_fall) begin
          if (bitcnt == 4'd9) begin
            bitcnt <= '0;
            state  <= nst;
            if (state == S_WDAT && sda_oe) ptr <= ptr + 8'd1;
            if (nst == S_RCNT || nst == S_RDAT) begin
              tx     <= ld_val;
              sda_oe <= ~ld_val[7];
            end else sda_oe <= 1'b0;
          end else if (bitcnt == 4'd8) begin
            if (tx_mode) sda_oe <= 1'b0;
            else begin
              bitcnt <= 4'd9;
              sda_oe <= 1'b0;
              nst    <= S_SKIP;
              case (state)
                S_DEV: if (sr[7:1] == DEV_ADDR) begin
                  sda_oe <= 1'b1;
                  nst    <= sr[0] ? S_RCNT : S_OFS;
                end
                S_OFS: begin
                  ptr    <= sr;
                  sda_oe <= 1'b1;
                  nst    <= S_CNT;
                end
                S_CNT: if (sr != 8'h00) begin
                  remain <= sr;
                  sda_oe <= 1'b1;
                  nst    <= S_WDAT;
                end
                S_WDAT: if (remain != 8'h00) begin
                  reg_we <= 1'b1;
                  remain <= remain - 8'd1;
                  sda_oe <= 1'b1;
                  nst    <= S_WDAT;
                end
                default: ;
              endcase
            end
          end else if (tx_mode && bitcnt != 4'd0) begin
            sda_oe <= ~tx[3'd7 - bitcnt[2:0]];
          end
        end
      end
    end
  end

  // R9: SDA moves only while SCL is low, or is released at START/STOP
  p_oe_on_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> ($past(!scl_s) || $past(start_det || stop_det)));

  // R2: write strobe lasts a single cycle
  p_we_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  // R8: STOP returns the engine to idle with the line released
  p_stop_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (state == S_IDLE && !sda_oe));

  // R7: a master NACK on sent data puts the engine off the bus
  p_nack_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_mode && scl_rise && bitcnt == 4'd8 && sda_s && !start_det && !stop_det)
      |=> (state == S_SKIP && !sda_oe));

  // R3: a skipped transfer never drives or writes
  p_skip_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SKIP || state == S_IDLE) |-> !reg_we);

  // R10: acknowledge held through the SCL high phase of the ninth bit
  p_ack_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bitcnt == 4'd9 && !tx_mode && sda_oe && scl_s && !start_det && !stop_det) |=> sda_oe);
endmodule

// File: tb/test_smbus_idx_slave.sv
module test_smbus_idx_slave;
  localparam int NREG = 7;
  localparam int Q = 16;
  localparam int H = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, reg_we;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic [7:0] regs [NREG];
  wire sda_line = sda_m & ~sda_oe;
  int n_run = 0, n_fail = 0;
  bit timeout = 1'b0;

  always #10 clk = ~clk;

  smbus_idx_slave #(.DEV_ADDR(7'h69), .NUM_REGS(NREG)) i_smbus_idx_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata));

  assign reg_rdata = (reg_addr < NREG) ? regs[reg_addr] : 8'hEE;
  always_ff @(posedge clk) if (reg_we && reg_addr < NREG) regs[reg_addr] <= reg_wdata;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    #(n * 20);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; cyc(Q); scl_m = 1'b1; cyc(Q);
    sda_m = 1'b0; cyc(Q); scl_m = 1'b0; cyc(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; cyc(Q); scl_m = 1'b1; cyc(Q); sda_m = 1'b1; cyc(Q);
  endtask

  task automatic wr_byte(input logic [7:0] b, output bit acked);
    bit lo_start;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; cyc(Q); scl_m = 1'b1; cyc(H); scl_m = 1'b0; cyc(Q);
    end
    sda_m = 1'b1; cyc(Q); scl_m = 1'b1; cyc(2);
    lo_start = ~sda_line;
    cyc(H - 4);
    acked = lo_start & ~sda_line;
    cyc(2); scl_m = 1'b0; cyc(Q);
  endtask

  task automatic rd_byte(input bit give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      cyc(Q); scl_m = 1'b1; cyc(H / 2); b[i] = sda_line; cyc(H / 2); scl_m = 1'b0; cyc(Q);
    end
    sda_m = give_ack ? 1'b0 : 1'b1;
    cyc(Q); scl_m = 1'b1; cyc(H); scl_m = 1'b0; cyc(Q);
    sda_m = 1'b1;
  endtask

  task automatic t_reset;
    chk(sda_oe == 1'b0, "R9 reset sda_oe", sda_oe, 0);
    chk(reg_we == 1'b0, "R9 reset reg_we", reg_we, 0);
  endtask

  task automatic t_write_basic;
    bit a;
    bus_start;
    wr_byte(8'hD2, a); chk(a, "R1 R10 ack D2", a, 1);
    wr_byte(8'h01, a); chk(a, "R2 ack index", a, 1);
    wr_byte(8'h03, a); chk(a, "R2 ack count", a, 1);
    wr_byte(8'hA1, a); chk(a, "R2 ack data0", a, 1);
    wr_byte(8'hA2, a); chk(a, "R2 ack data1", a, 1);
    wr_byte(8'hA3, a); chk(a, "R2 ack data2", a, 1);
    bus_stop;
    chk(regs[1] == 8'hA1, "R2 reg1", regs[1], 8'hA1);
    chk(regs[2] == 8'hA2, "R2 reg2", regs[2], 8'hA2);
    chk(regs[3] == 8'hA3, "R2 reg3", regs[3], 8'hA3);
    chk(regs[0] == 8'h10, "R2 reg0 untouched", regs[0], 8'h10);
    chk(regs[4] == 8'h14, "R2 reg4 untouched", regs[4], 8'h14);
  endtask

  task automatic t_bad_addr;
    bit a;
    bus_start;
    wr_byte(8'hA4, a); chk(!a, "R1 foreign address not acked", a, 0);
    wr_byte(8'h00, a); chk(!a, "R1 no ack after foreign address", a, 0);
    wr_byte(8'h01, a);
    wr_byte(8'h99, a);
    bus_stop;
    chk(regs[0] == 8'h10, "R1 reg0 unchanged", regs[0], 8'h10);
  endtask

  task automatic t_zero_cnt;
    bit a;
    bus_start;
    wr_byte(8'hD2, a);
    wr_byte(8'h00, a);
    wr_byte(8'h00, a); chk(!a, "R3 zero count nacked", a, 0);
    wr_byte(8'h55, a); chk(!a, "R3 data after zero count nacked", a, 0);
    bus_stop;
    chk(regs[0] == 8'h10, "R3 reg0 unchanged", regs[0], 8'h10);
  endtask

  task automatic t_excess;
    bit a;
    bus_start;
    wr_byte(8'hD2, a);
    wr_byte(8'h05, a);
    wr_byte(8'h01, a);
    wr_byte(8'h11, a); chk(a, "R4 counted byte acked", a, 1);
    wr_byte(8'h22, a); chk(!a, "R4 extra byte nacked", a, 0);
    bus_stop;
    chk(regs[5] == 8'h11, "R4 reg5", regs[5], 8'h11);
    chk(regs[6] == 8'h16, "R4 reg6 unchanged", regs[6], 8'h16);
  endtask

  task automatic read_setup(input logic [7:0] idx);
    bit a;
    bus_start;
    wr_byte(8'hD2, a);
    wr_byte(idx, a);
    bus_start;
    wr_byte(8'hD3, a); chk(a, "R1 ack D3", a, 1);
  endtask

  task automatic t_read_basic;
    logic [7:0] b;
    read_setup(8'h01);
    rd_byte(1'b1, b); chk(b == 8'h06, "R5 count from index 1", b, 6);
    rd_byte(1'b1, b); chk(b == 8'hA1, "R5 data reg1", b, 8'hA1);
    rd_byte(1'b1, b); chk(b == 8'hA2, "R5 data reg2", b, 8'hA2);
    rd_byte(1'b0, b); chk(b == 8'hA3, "R5 data reg3", b, 8'hA3);
    bus_stop;
  endtask

  task automatic t_read_end;
    logic [7:0] b;
    read_setup(8'h06);
    rd_byte(1'b1, b); chk(b == 8'h01, "R5 count at last reg", b, 1);
    rd_byte(1'b1, b); chk(b == 8'h16, "R5 data reg6", b, 8'h16);
    rd_byte(1'b0, b); chk(b == 8'h00, "R6 past end reads 00", b, 0);
    bus_stop;
    read_setup(8'h09);
    rd_byte(1'b0, b); chk(b == 8'h00, "R6 count beyond map", b, 0);
    bus_stop;
  endtask

  task automatic t_nack_release;
    logic [7:0] b;
    read_setup(8'h00);
    rd_byte(1'b1, b); chk(b == 8'h07, "R5 count from index 0", b, 7);
    rd_byte(1'b0, b); chk(b == 8'h10, "R5 data reg0", b, 8'h10);
    rd_byte(1'b0, b); chk(b == 8'hFF, "R7 line released after NACK", b, 8'hFF);
    bus_stop;
  endtask

  task automatic t_abort;
    bit a;
    bus_start;
    wr_byte(8'hD2, a);
    wr_byte(8'h02, a);
    wr_byte(8'h03, a);
    wr_byte(8'h77, a);
    bus_start;
    bus_stop;
    chk(regs[2] == 8'h77, "R8 written byte kept", regs[2], 8'h77);
    chk(regs[3] == 8'hA3, "R8 unsent byte untouched", regs[3], 8'hA3);
    bus_start;
    wr_byte(8'hD2, a); chk(a, "R8 next transfer acked", a, 1);
    wr_byte(8'h03, a);
    wr_byte(8'h01, a);
    wr_byte(8'h5C, a);
    bus_stop;
    chk(regs[3] == 8'h5C, "R8 next transfer writes", regs[3], 8'h5C);
  endtask

  initial begin
    for (int i = 0; i < NREG; i++) regs[i] = 8'h10 + 8'(i);
    @(negedge clk);
    cyc(5);
    fork
      begin
        t_reset;
        rst_n = 1'b1;
        cyc(10);
        t_write_basic;
        t_bad_addr;
        t_zero_cnt;
        t_excess;
        t_read_basic;
        t_read_end;
        t_nack_release;
        t_abort;
      end
      begin
        cyc(150000);
        timeout = 1'b1;
      end
    join_any
    if (timeout) chk(1'b0, "watchdog", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule